// File: doc/BRIEF.md
# Deserializer Lane Calibration Sequencer

This block runs the receive-side calibration of a group of deserializer lanes. It holds off while the clock generator is unlocked. Once the lock is present and the block's own reset output has dropped, it waits for a start pulse of a valid length. It then asks the remote transmitter to send the agreed training word, and it waits a bounded time for that transmitter to acknowledge.

With the acknowledge in, it hands control to a sweep engine clocked by the quarter-rate delay clock. For each lane in turn, the engine presents every input-delay tap and asks an external comparator whether the deserialized word matches the training word. It then writes the centre of the best passing window into that lane's delay register, in place of the lane's default tap. After a clean sweep the word-clock side asks an external word aligner to run. The sequencer finishes in a sticky done or error state, which only a loss of lock clears.

The two clock domains exchange only toggle events through two-flop synchronisers, plus one result level that is held stable before its event toggles.

Top module: `rx_cal_sequencer`

## Requirements
- R1: `rst_out` is high whenever `pll_locked` is low and falls on the second `wclk` rising edge after lock rises. While it is high, every request, done and error output is low, and start pulses are discarded.
- R2: A start pulse is accepted only if `start_pulse` is seen high on 2 to 16 consecutive `wclk` edges. The length is judged at the first edge that sees it low. `train_req` rises after that same edge. Pulses of 1 or of 17 or more edges leave `train_req` low.
- R3: `train_req` stays high through the tap sweep and the word alignment. It falls in the same cycle that done or error is raised.
- R4: No compare request is issued before `train_ack` is seen high. If `train_ack` stays low, `train_req` is high for exactly `ACK_TIMEOUT` cycles, then `cal_error` rises and `train_req` falls.
- R5: The sweep visits lanes 0 upward and taps 0 to `TAPS-1` within each lane. Each tap gets one compare request, which is held with `probe_tap` and `dly_lane` steady until `cmp_ack`.
- R6: For each lane that has at least one match, exactly one `dly_we` pulse is issued. It writes start + (length-1)/2 (rounded down) of the longest run of consecutive matching taps. Among runs of equal length, the lowest-numbered run wins.
- R7: A lane with no matching tap gets no write, and the sweep still covers the remaining lanes. At the end `cal_error` rises and `align_req` is never raised.
- R8: After a clean sweep, `align_req` is held until `align_done`. The state after that edge is done if `align_ok` is 1, or error if it is 0. Done and error are never high together.
- R9: `cal_done` and `cal_error` stay high until `rst_out` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Word clock |
| dclk | input | 1 | Delay-register clock, one quarter of the word clock |
| pll_locked | input | 1 | Clock generator lock indication |
| rst_out | output | 1 | Reset for the rest of the receiver, high while unlocked |
| start_pulse | input | 1 | Calibration start pulse (word-clock domain) |
| train_req | output | 1 | Asks the remote transmitter to send the training word |
| train_ack | input | 1 | Remote transmitter is sending the training word |
| cmp_req | output | 1 | Compare request for the presented lane and tap (dclk) |
| dly_lane | output | $clog2(LANES) | Lane being swept or written |
| probe_tap | output | $clog2(TAPS) | Tap applied for the current compare |
| cmp_ack | input | 1 | Comparator has a result (dclk) |
| cmp_match | input | 1 | Result: the training word matched, valid with cmp_ack |
| dly_we | output | 1 | Writes the chosen tap into the lane's delay register (dclk) |
| dly_value | output | $clog2(TAPS) | Chosen tap for dly_we |
| align_req | output | 1 | Runs the external word aligner |
| align_done | input | 1 | Word aligner finished |
| align_ok | input | 1 | Word aligner succeeded, valid with align_done |
| cal_done | output | 1 | Calibration complete |
| cal_error | output | 1 | Calibration failed |

## Verification
`train_req` is due one `wclk` cycle after the first low sample of an accepted pulse, so the bench samples it at the falling edge that follows. `cal_done` and `cal_error` are due one cycle after the edge that sees `align_done`, and the bench reads them at the next falling edge. The timeout is measured by counting the falling edges at which `train_req` is high, and the count must equal `ACK_TIMEOUT`. The tap sweep crosses clock domains, so its latency is not fixed. Its results are therefore logged as events on falling `dclk` edges: tap order and delay writes are recorded and compared, once the sweep ends, against windows the bench computes from its own random match masks.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_REQ, W_SWEEP, W_ALIGN, W_DONE, W_ERR
  } wstate_t;

  typedef enum logic [2:0] {
    D_IDLE, D_ASK, D_NEXT, D_WRITE, D_FIN
  } dstate_t;
endpackage

// File: rtl/cal_pulse_qual.sv
`timescale 1ns/1ps
module cal_pulse_qual #(
  parameter int MIN_LEN = 2,
  parameter int MAX_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic accept
);
  localparam int CW = $clog2(MAX_LEN + 2);
  localparam logic [CW-1:0] SAT = CW'(MAX_LEN + 1);
  localparam logic [CW-1:0] LO  = CW'(MIN_LEN);
  localparam logic [CW-1:0] HI  = CW'(MAX_LEN);

  logic [CW-1:0] run_len;

  // length test, evaluated on the first low sample
  function automatic logic len_ok(input logic [CW-1:0] n);
    return (n >= LO) && (n <= HI);
  endfunction

  always_ff @(posedge clk or posedge rst) begin
    if (rst) run_len <= '0;
    else if (lvl) begin
      if (run_len != SAT) run_len <= run_len + 1'b1;
    end else run_len <= '0;
  end

  assign accept = !lvl && len_ok(run_len);
endmodule

// File: rtl/cal_toggle_sync.sv
`timescale 1ns/1ps
module cal_toggle_sync (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic evt
);
  logic [2:0] shr;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) shr <= '0;
    else     shr <= {shr[1:0], tgl_in};
  end

  assign evt = shr[2] ^ shr[1];
endmodule

// File: rtl/cal_tap_sweep.sv
`timescale 1ns/1ps
module cal_tap_sweep import cal_pkg::*; #(
  parameter int LANES = 4,
  parameter int TAPS  = 16
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   go,
  output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] lane_sel,
  output logic [$clog2(TAPS)-1:0]                probe_tap,
  output logic                                   cmp_req,
  input  logic                                   cmp_ack,
  input  logic                                   cmp_match,
  output logic                                   dly_we,
  output logic [$clog2(TAPS)-1:0]                dly_value,
  output logic                                   fin_tgl,
  output logic                                   fin_fail
);
  localparam int TW = $clog2(TAPS);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int NW = $clog2(TAPS + 1);
  localparam logic [TW-1:0] LAST_TAP  = TW'(TAPS - 1);
  localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

  dstate_t       st;
  logic [TW-1:0] tap;
  logic [LW-1:0] lane;
  logic [NW-1:0] cur_len, best_len, len_next;
  logic [TW-1:0] cur_first, best_first, first_next;

  // lower middle of a window
  function automatic logic [TW-1:0] centre_of(input logic [TW-1:0] first,
                                              input logic [NW-1:0] len);
    logic [NW-1:0] half;
    half = (len - 1'b1) >> 1;
    return first + TW'(half);
  endfunction

  always_comb begin
    len_next   = cmp_match ? cur_len + 1'b1 : '0;
    first_next = (cmp_match && cur_len == '0) ? tap : cur_first;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st         <= D_IDLE;
      tap        <= '0;
      lane       <= '0;
      cur_len    <= '0;
      best_len   <= '0;
      cur_first  <= '0;
      best_first <= '0;
      fin_tgl    <= 1'b0;
      fin_fail   <= 1'b0;
    end else begin
      case (st)
        D_IDLE: if (go) begin
          st         <= D_ASK;
          tap        <= '0;
          lane       <= '0;
          cur_len    <= '0;
          best_len   <= '0;
          cur_first  <= '0;
          best_first <= '0;
          fin_fail   <= 1'b0;
        end
        D_ASK: if (cmp_ack) begin
          cur_len   <= len_next;
          cur_first <= first_next;
          if (cmp_match && len_next > best_len) begin
            best_len   <= len_next;
            best_first <= first_next;
          end
          st <= D_NEXT;
        end
        D_NEXT: begin
          if (tap == LAST_TAP) st <= D_WRITE;
          else begin
            tap <= tap + 1'b1;
            st  <= D_ASK;
          end
        end
        D_WRITE: begin
          if (best_len == '0) fin_fail <= 1'b1;
          if (lane == LAST_LANE) st <= D_FIN;
          else begin
            lane       <= lane + 1'b1;
            tap        <= '0;
            cur_len    <= '0;
            best_len   <= '0;
            cur_first  <= '0;
            best_first <= '0;
            st         <= D_ASK;
          end
        end
        D_FIN: begin
          fin_tgl <= ~fin_tgl;
          st      <= D_IDLE;
        end
        default: st <= D_IDLE;
      endcase
    end
  end

  assign cmp_req   = (st == D_ASK);
  assign dly_we    = (st == D_WRITE) && (best_len != '0);
  assign dly_value = centre_of(best_first, best_len);
  assign probe_tap = tap;
  assign lane_sel  = lane;
endmodule

// File: rtl/rx_cal_sequencer.sv
`timescale 1ns/1ps
module rx_cal_sequencer import cal_pkg::*; #(
  parameter int LANES       = 4,
  parameter int TAPS        = 16,
  parameter int ACK_TIMEOUT = 1024,
  parameter int START_MIN   = 2,
  parameter int START_MAX   = 16
) (
  input  logic                                         wclk,
  input  logic                                         dclk,
  input  logic                                         pll_locked,
  output logic                                         rst_out,
  input  logic                                         start_pulse,
  output logic                                         train_req,
  input  logic                                         train_ack,
  output logic                                         cmp_req,
  output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] dly_lane,
  output logic [$clog2(TAPS)-1:0]                      probe_tap,
  input  logic                                         cmp_ack,
  input  logic                                         cmp_match,
  output logic                                         dly_we,
  output logic [$clog2(TAPS)-1:0]                      dly_value,
  output logic                                         align_req,
  input  logic                                         align_done,
  input  logic                                         align_ok,
  output logic                                         cal_done,
  output logic                                         cal_error
);
  localparam int CNTW = $clog2(ACK_TIMEOUT + 1);
  localparam logic [CNTW-1:0] WAIT_LAST = CNTW'(ACK_TIMEOUT - 1);

  // named internal events (observed by the checker)
  logic pulse_ok, ack_timeout, go_evt, fin_evt, d_rst;
  logic go_tgl, fin_tgl, fin_fail;
  logic [1:0] rst_sync, drst_sync;
  logic [CNTW-1:0] wait_cnt;
  wstate_t st;

  // word-clock reset: asserted with lock loss, released two edges after lock
  always_ff @(posedge wclk or negedge pll_locked) begin
    if (!pll_locked) rst_sync <= 2'b11;
    else             rst_sync <= {rst_sync[0], 1'b0};
  end
  assign rst_out = rst_sync[1];

  // delay-clock reset follows rst_out
  always_ff @(posedge dclk or posedge rst_out) begin
    if (rst_out) drst_sync <= 2'b11;
    else         drst_sync <= {drst_sync[0], 1'b0};
  end
  assign d_rst = drst_sync[1];

  cal_pulse_qual #(.MIN_LEN(START_MIN), .MAX_LEN(START_MAX)) i_qual (
    .clk(wclk), .rst(rst_out), .lvl(start_pulse), .accept(pulse_ok)
  );

  cal_toggle_sync i_go_sync (
    .clk(dclk), .rst(d_rst), .tgl_in(go_tgl), .evt(go_evt)
  );

  cal_toggle_sync i_fin_sync (
    .clk(wclk), .rst(rst_out), .tgl_in(fin_tgl), .evt(fin_evt)
  );

  cal_tap_sweep #(.LANES(LANES), .TAPS(TAPS)) i_sweep (
    .clk(dclk), .rst(d_rst), .go(go_evt),
    .lane_sel(dly_lane), .probe_tap(probe_tap),
    .cmp_req(cmp_req), .cmp_ack(cmp_ack), .cmp_match(cmp_match),
    .dly_we(dly_we), .dly_value(dly_value),
    .fin_tgl(fin_tgl), .fin_fail(fin_fail)
  );

  assign ack_timeout = (st == W_REQ) && !train_ack && (wait_cnt == WAIT_LAST);

  always_ff @(posedge wclk or posedge rst_out) begin
    if (rst_out) begin
      st       <= W_IDLE;
      wait_cnt <= '0;
      go_tgl   <= 1'b0;
    end else begin
      case (st)
        W_IDLE: if (pulse_ok) begin
          st       <= W_REQ;
          wait_cnt <= '0;
        end
        W_REQ: begin
          if (train_ack) begin
            st     <= W_SWEEP;
            go_tgl <= ~go_tgl;
          end else if (ack_timeout) st <= W_ERR;
          else wait_cnt <= wait_cnt + 1'b1;
        end
        W_SWEEP: if (fin_evt) st <= fin_fail ? W_ERR : W_ALIGN;
        W_ALIGN: if (align_done) st <= align_ok ? W_DONE : W_ERR;
        default: st <= st;
      endcase
    end
  end

  assign train_req = (st == W_REQ) || (st == W_SWEEP) || (st == W_ALIGN);
  assign align_req = (st == W_ALIGN);
  assign cal_done  = (st == W_DONE);
  assign cal_error = (st == W_ERR);
endmodule

// File: rtl/cal_seq_checker.sv
`timescale 1ns/1ps
module cal_seq_checker (
  input logic wclk,
  input logic dclk,
  input logic rst_out,
  input logic d_rst,
  input logic pulse_ok,
  input logic train_req,
  input logic align_req,
  input logic align_done,
  input logic align_ok,
  input logic cal_done,
  input logic cal_error,
  input logic cmp_req,
  input logic cmp_ack,
  input logic dly_we
);
  AST_REQ_NEEDS_PULSE: assert property (@(posedge wclk) disable iff (rst_out !== 1'b0)
    $rose(train_req) |-> $past(pulse_ok)); // R2

  AST_REQ_OFF_AT_END: assert property (@(posedge wclk) disable iff (rst_out !== 1'b0)
    (cal_done || cal_error) |-> !train_req); // R3

  AST_DONE_CAUSE: assert property (@(posedge wclk) disable iff (rst_out !== 1'b0)
    $rose(cal_done) |-> $past(align_req && align_done && align_ok)); // R8

  AST_ONE_OUTCOME: assert property (@(posedge wclk) disable iff (rst_out !== 1'b0)
    !(cal_done && cal_error)); // R8

  AST_DONE_STICKY: assert property (@(posedge wclk) disable iff (rst_out !== 1'b0)
    cal_done |=> cal_done); // R9

  AST_ERROR_STICKY: assert property (@(posedge wclk) disable iff (rst_out !== 1'b0)
    cal_error |=> cal_error); // R9

  AST_PROBE_HELD: assert property (@(posedge dclk) disable iff (d_rst !== 1'b0)
    (cmp_req && !cmp_ack) |=> cmp_req); // R5

  AST_WRITE_SINGLE: assert property (@(posedge dclk) disable iff (d_rst !== 1'b0)
    dly_we |=> !dly_we); // R6
endmodule

bind rx_cal_sequencer cal_seq_checker i_chk (
  .wclk(wclk), .dclk(dclk), .rst_out(rst_out), .d_rst(d_rst),
  .pulse_ok(pulse_ok), .train_req(train_req), .align_req(align_req),
  .align_done(align_done), .align_ok(align_ok), .cal_done(cal_done),
  .cal_error(cal_error), .cmp_req(cmp_req), .cmp_ack(cmp_ack), .dly_we(dly_we)
);

// File: tb/test_rx_cal_sequencer.sv
`timescale 1ns/1ps
module test_rx_cal_sequencer;
  localparam int LANES = 4;
  localparam int TAPS  = 16;
  localparam int TMO   = 64;

  logic wclk = 1'b0, dclk = 1'b0;
  logic pll_locked = 1'b0, start_pulse = 1'b0, train_ack = 1'b0;
  logic align_done = 1'b0, align_ok = 1'b0, cmp_ack = 1'b0, cmp_match = 1'b0;
  logic rst_out, train_req, cmp_req, dly_we, align_req, cal_done, cal_error;
  logic [1:0] dly_lane;
  logic [3:0] probe_tap, dly_value;

  rx_cal_sequencer #(.LANES(LANES), .TAPS(TAPS), .ACK_TIMEOUT(TMO)) i_rx_cal_sequencer (
    .wclk(wclk), .dclk(dclk), .pll_locked(pll_locked), .rst_out(rst_out),
    .start_pulse(start_pulse), .train_req(train_req), .train_ack(train_ack),
    .cmp_req(cmp_req), .dly_lane(dly_lane), .probe_tap(probe_tap),
    .cmp_ack(cmp_ack), .cmp_match(cmp_match), .dly_we(dly_we), .dly_value(dly_value),
    .align_req(align_req), .align_done(align_done), .align_ok(align_ok),
    .cal_done(cal_done), .cal_error(cal_error)
  );

  always #2 wclk = ~wclk;                       // 250 MHz
  initial begin #1; forever #8 dclk = ~dclk; end // quarter rate, offset

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [TAPS-1:0] mask [LANES];
  int wr_seen [LANES];
  int wr_val [LANES];
  int exp_lane = 0, exp_tap = 0, order_err = 0, probe_cnt = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // comparator model and write logger
  always @(negedge dclk) begin
    if (dly_we) begin
      wr_seen[dly_lane] = wr_seen[dly_lane] + 1;
      wr_val[dly_lane]  = int'(dly_value);
    end
    if (cmp_req && !cmp_ack) begin
      probe_cnt++;
      if (int'(dly_lane) != exp_lane || int'(probe_tap) != exp_tap) order_err++;
      cmp_match = mask[dly_lane][probe_tap];
      cmp_ack   = 1'b1;
      exp_tap++;
      if (exp_tap == TAPS) begin exp_tap = 0; exp_lane++; end
    end else cmp_ack = 1'b0;
  end

  // earliest longest window, centre rounded down; -1 if none
  function automatic int best_centre(input logic [TAPS-1:0] m);
    int bl = 0, bs = 0;
    for (int s = 0; s < TAPS; s++) begin
      int l = 0;
      while (s + l < TAPS && m[s+l]) l++;
      if (l > bl) begin bl = l; bs = s; end
    end
    if (bl == 0) return -1;
    return bs + (bl - 1) / 2;
  endfunction

  task automatic do_reset(input bit chk);
    pll_locked = 1'b0; train_ack = 1'b0; align_done = 1'b0; start_pulse = 1'b0;
    repeat (4) @(negedge wclk);
    if (chk) begin
      check("R1 rst_out while unlocked", int'(rst_out), 1);
      check("R1 outputs idle in reset",
            int'({train_req, align_req, cal_done, cal_error, cmp_req}), 0);
    end
    pll_locked = 1'b1;
    @(negedge wclk);
    if (chk) check("R1 rst_out after one edge", int'(rst_out), 1);
    @(negedge wclk);
    if (chk) check("R1 rst_out released", int'(rst_out), 0);
    repeat (10) @(negedge wclk);
  endtask

  task automatic send_pulse(input int n);
    start_pulse = 1'b1;
    repeat (n) @(negedge wclk);
    start_pulse = 1'b0;
  endtask

  task automatic run_cal(input int plen, input int ack_wait, input bit aok);
    int exp_c [LANES];
    bit any_bad = 1'b0;
    int guard = 0;
    for (int i = 0; i < LANES; i++) begin
      exp_c[i] = best_centre(mask[i]);
      if (exp_c[i] < 0) any_bad = 1'b1;
      wr_seen[i] = 0; wr_val[i] = -1;
    end
    exp_lane = 0; exp_tap = 0; order_err = 0; probe_cnt = 0;
    send_pulse(plen);
    @(negedge wclk);
    check("R2 request after valid pulse", int'(train_req), 1);
    repeat (ack_wait) @(negedge wclk);
    check("R4 no probe before ack", probe_cnt, 0);
    train_ack = 1'b1;
    while (!align_req && !cal_error && guard < 40000) begin
      @(negedge wclk); guard++;
    end
    check("R5 probe count", probe_cnt, LANES * TAPS);
    check("R5 probe order errors", order_err, 0);
    for (int i = 0; i < LANES; i++) begin
      if (exp_c[i] < 0) check("R7 no write for failing lane", wr_seen[i], 0);
      else begin
        check("R6 one write per lane", wr_seen[i], 1);
        check("R6 written centre", wr_val[i], exp_c[i]);
      end
    end
    if (any_bad) begin
      check("R7 error on failing lane", int'(cal_error), 1);
      check("R7 no alignment", int'(align_req), 0);
      check("R3 request dropped at error", int'(train_req), 0);
    end else begin
      check("R8 alignment requested", int'(align_req), 1);
      check("R3 request held in alignment", int'(train_req), 1);
      repeat (3) @(negedge wclk);
      check("R8 alignment held", int'(align_req), 1);
      align_ok = aok; align_done = 1'b1;
      @(negedge wclk);
      align_done = 1'b0;
      check("R8 done outcome", int'(cal_done), int'(aok));
      check("R8 error outcome", int'(cal_error), int'(!aok));
      check("R3 request dropped at end", int'(train_req), 0);
    end
    repeat (6) @(negedge wclk);
    check("R9 outcome held", int'(cal_done | cal_error), 1);
    train_ack = 1'b0;
  endtask

  initial begin
    int n;
    void'($urandom(32'h5EED));
    for (int i = 0; i < LANES; i++) begin wr_seen[i] = 0; wr_val[i] = -1; end
    do_reset(1'b1);

    // R1: pulse while unlocked is discarded
    pll_locked = 1'b0;
    repeat (3) @(negedge wclk);
    send_pulse(4);
    repeat (3) @(negedge wclk);
    check("R1 rst_out follows lock", int'(rst_out), 1);
    pll_locked = 1'b1;
    repeat (12) @(negedge wclk);
    check("R1 pulse in reset ignored", int'(train_req), 0);

    // R2: too short and too long
    send_pulse(1);
    repeat (5) @(negedge wclk);
    check("R2 one-cycle pulse ignored", int'(train_req), 0);
    send_pulse(17);
    repeat (5) @(negedge wclk);
    check("R2 17-cycle pulse ignored", int'(train_req), 0);

    // R4: acknowledge timeout, with the longest valid pulse
    probe_cnt = 0;
    send_pulse(16);
    @(negedge wclk);
    n = 0;
    while (train_req && n < 1000) begin n++; @(negedge wclk); end
    check("R4 request length before timeout", n, TMO);
    check("R4 error after timeout", int'(cal_error), 1);
    check("R4 no probe without ack", probe_cnt, 0);

    // directed windows: full, last tap, equal runs, even run
    do_reset(1'b0);
    mask[0] = 16'hFFFF; mask[1] = 16'h8000; mask[2] = 16'h0E0E; mask[3] = 16'h00F0;
    run_cal(2, 0, 1'b1);

    // R7: one lane never matches
    do_reset(1'b0);
    mask[0] = 16'h0018; mask[1] = 16'h0001; mask[2] = 16'h0000; mask[3] = 16'h3FFC;
    run_cal(9, 5, 1'b1);

    // R8: aligner fails
    do_reset(1'b0);
    mask[0] = 16'h00FF; mask[1] = 16'h7F00; mask[2] = 16'h0F0F; mask[3] = 16'h1111;
    run_cal(16, 12, 1'b0);

    // constrained random runs
    for (int r = 0; r < 6; r++) begin
      do_reset(1'b0);
      for (int i = 0; i < LANES; i++) begin
        mask[i] = TAPS'($urandom);
        if ($urandom % 10 == 0) mask[i] = '0;
      end
      run_cal(2 + int'($urandom % 15), int'($urandom % 20), ($urandom % 4) != 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule